// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This block is a registered arithmetic stage for packed 16-bit data held in 32-bit words. Each operand word is taken as two signed halfwords. The unit multiplies the two low halves together and the two high halves together. It then adds the two products, or subtracts the high-half product from the low-half product. The operand B halfwords can first be exchanged, so that the low half of A meets the high half of B.

The combined value can be returned as it is, added to a 32-bit accumulator, or, in wide mode, added to a 64-bit accumulator supplied as a high word and a low word. In wide mode both products are widened to 64 bits before they are combined, so a sum of two large positive products stays positive. A sticky saturation flag records signed overflow of the narrow additions. Wide mode never raises it.

A request is taken on a rising clock edge when `in_valid` is high. The result and a matching `out_valid` appear one cycle later and stay unchanged until the next request.

Top module: `dual_half_mac`

## Requirements
- R1: When `swap_b` is 1, the two halfwords of `op_b` are exchanged before multiplication: bits 15:0 are used as the high half and bits 31:16 as the low half.
- R2: The low product is signed `op_a[15:0]` times the signed low half of B. The high product is signed `op_a[31:16]` times the signed high half of B. When `sub_mode` is 0, the two products are added.
- R3: When `sub_mode` is 1, the combined value is the low product minus the high product.
- R4: When `long_mode` is 1, each product is sign-extended to 64 bits before the two are combined. Two products of 0x40000000 give `res_hi`=0x00000000 and `res_lo`=0x80000000.
- R5: In wide mode with `acc_en` at 1, the 64-bit signed value `{acc_hi, acc_lo}` is added, with wrap modulo 2^64. Result bits 63:32 go to `res_hi` and bits 31:0 go to `res_lo`. With `acc_en` at 0, no accumulator is added.
- R6: A wide-mode request never sets `q_out` by itself.
- R7: In narrow mode with addition, signed 32-bit overflow of the product sum sets `q_out`. A narrow subtraction of the products never sets it.
- R8: In narrow mode with `acc_en` at 1, `acc_lo` is added to the 32-bit dual result, with wrap modulo 2^32. Signed overflow of that addition sets `q_out`. `acc_hi` is ignored.
- R9: In narrow mode with `acc_en` at 0, `res_lo` is the 32-bit dual result. In narrow mode `res_hi` is always 0.
- R10: `q_out` is sticky. An accepted request with `q_in` at 1 sets it. `q_clr` at 1 clears it on the next edge, whether or not `in_valid` is high, and takes priority over any set in that same cycle.
- R11: `out_valid` goes high one cycle after an accepted request. When `in_valid` is 0, `out_valid` drops the next cycle and `res_hi` and `res_lo` keep their values.
- R12: A synchronous active-high `rst` clears `out_valid`, `q_out`, `res_hi` and `res_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request accepted on this edge |
| op_a | input | 32 | Packed halfword operand A |
| op_b | input | 32 | Packed halfword operand B |
| acc_hi | input | 32 | Accumulator high word (wide mode) |
| acc_lo | input | 32 | Accumulator low word / narrow accumulator |
| swap_b | input | 1 | Exchange halfwords of B |
| sub_mode | input | 1 | Subtract high product from low product |
| long_mode | input | 1 | 64-bit wide accumulate mode |
| acc_en | input | 1 | Add the accumulator |
| q_in | input | 1 | Incoming saturation flag, ORed in |
| q_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word |
| q_out | output | 1 | Sticky saturation flag |

## Verification
A faulty sign extension in wide mode shows at the ports in the same cycle as the result. With the 0x8000×0x8000 pair in both lanes, `res_hi` reads 0xFFFFFFFF instead of zero. A wrong flag update is harder to spot, because the flag is sticky and hides later events until it is cleared. For that reason each flag case starts from a cleared flag and is checked one cycle after its request. A lost hold or a lost valid bit shows one cycle after an idle input.

// File: rtl/dhm_pkg.sv
package dhm_pkg;
    // width class of the accumulation stage
    typedef enum logic {
        ACC_NARROW = 1'b0,
        ACC_WIDE   = 1'b1
    } acc_width_e;

    localparam int DHM_LANES = 2;
endpackage

// File: rtl/dhm_lanes.sv
module dhm_lanes #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]                       op_a_i,
    input  logic [DW-1:0]                       op_b_i,
    input  logic                                swap_i,
    output logic [dhm_pkg::DHM_LANES-1:0][DW-1:0] prod_o
);
    localparam int HW = DW / 2;

    for (genvar g = 0; g < dhm_pkg::DHM_LANES; g++) begin : g_lane
        logic signed [HW-1:0] a_half;
        logic signed [HW-1:0] b_half;
        logic signed [DW-1:0] p_lane;

        always_comb begin
            a_half = op_a_i[g*HW +: HW];
            // exchanged halves: lane g reads the opposite half of B
            b_half = swap_i ? op_b_i[(1-g)*HW +: HW] : op_b_i[g*HW +: HW];
            p_lane = a_half * b_half;
        end

        assign prod_o[g] = p_lane;
    end
endmodule

// File: rtl/dhm_combine.sv
module dhm_combine
    import dhm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] prod_lo_i,
    input  logic [DW-1:0] prod_hi_i,
    input  logic [DW-1:0] acc_hi_i,
    input  logic [DW-1:0] acc_lo_i,
    input  logic          sub_i,
    input  acc_width_e    width_i,
    input  logic          acc_en_i,
    output logic [DW-1:0] res_hi_o,
    output logic [DW-1:0] res_lo_o,
    output logic          ovf_o
);
    localparam int LW = 2 * DW;

    logic [LW-1:0] p1_x, p2_x, dual_x, acc_x, wide_sum;
    logic [DW-1:0] dual_n, acc_n;
    logic [DW:0]   narrow_sum;
    logic          ovf_dual, ovf_acc;

    always_comb begin
        // widen both products before combining them
        p1_x   = {{DW{prod_lo_i[DW-1]}}, prod_lo_i};
        p2_x   = {{DW{prod_hi_i[DW-1]}}, prod_hi_i};
        dual_x = sub_i ? (p1_x - p2_x) : (p1_x + p2_x);

        // wide path
        acc_x    = acc_en_i ? {acc_hi_i, acc_lo_i} : '0;
        wide_sum = dual_x + acc_x;

        // narrow path: exact dual value fits in DW+1 bits
        dual_n     = dual_x[DW-1:0];
        ovf_dual   = !sub_i && (dual_x[DW] != dual_x[DW-1]);
        acc_n      = acc_en_i ? acc_lo_i : '0;
        narrow_sum = {dual_n[DW-1], dual_n} + {acc_n[DW-1], acc_n};
        ovf_acc    = acc_en_i && (narrow_sum[DW] != narrow_sum[DW-1]);

        if (width_i == ACC_WIDE) begin
            res_hi_o = wide_sum[LW-1:DW];
            res_lo_o = wide_sum[DW-1:0];
            ovf_o    = 1'b0;
        end else begin
            res_hi_o = '0;
            res_lo_o = narrow_sum[DW-1:0];
            ovf_o    = ovf_dual | ovf_acc;
        end
    end
endmodule

// File: rtl/dual_half_mac.sv
module dual_half_mac
    import dhm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] acc_hi,
    input  logic [DW-1:0] acc_lo,
    input  logic          swap_b,
    input  logic          sub_mode,
    input  logic          long_mode,
    input  logic          acc_en,
    input  logic          q_in,
    input  logic          q_clr,
    output logic          out_valid,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo,
    output logic          q_out
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          q;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [DHM_LANES-1:0][DW-1:0] prod;
    logic [DW-1:0]                 cmb_hi, cmb_lo;
    logic                          cmb_ovf;
    acc_width_e                    width_sel;

    assign width_sel = long_mode ? ACC_WIDE : ACC_NARROW;

    dhm_lanes #(.DW(DW)) i_lanes (
        .op_a_i (op_a),
        .op_b_i (op_b),
        .swap_i (swap_b),
        .prod_o (prod)
    );

    dhm_combine #(.DW(DW)) i_combine (
        .prod_lo_i (prod[0]),
        .prod_hi_i (prod[1]),
        .acc_hi_i  (acc_hi),
        .acc_lo_i  (acc_lo),
        .sub_i     (sub_mode),
        .width_i   (width_sel),
        .acc_en_i  (acc_en),
        .res_hi_o  (cmb_hi),
        .res_lo_o  (cmb_lo),
        .ovf_o     (cmb_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.hi = cmb_hi;
            st_d.lo = cmb_lo;
        end
        st_d.q = q_clr ? 1'b0 : (st_q.q | (in_valid & (q_in | cmb_ovf)));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_hi    = st_q.hi;
    assign res_lo    = st_q.lo;
    assign q_out     = st_q.q;

    // flag rules
    p_long_no_q_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && long_mode && !q_in && !q_clr && !q_out) |=> !q_out);
    p_sub_no_q_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_mode && sub_mode && !acc_en && !q_in && !q_out) |=> !q_out);
    p_q_set_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q_in && !q_clr) |=> q_out);
    p_q_clr_r10: assert property (@(posedge clk) disable iff (rst)
        q_clr |=> !q_out);
    p_q_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (q_out && !q_clr) |=> q_out);
    // handshake and hold
    p_vld_up_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_vld_dn_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_hi) && $stable(res_lo)));
endmodule

// File: tb/test_dual_half_mac.sv
module test_dual_half_mac;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, swap_b, sub_mode, long_mode, acc_en, q_in, q_clr;
    logic [31:0] op_a, op_b, acc_hi, acc_lo;
    logic        out_valid, q_out;
    logic [31:0] res_hi, res_lo;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] exp_hi = '0, exp_lo = '0;
    logic        exp_q  = 1'b0;

    always #4 clk = ~clk;

    dual_half_mac i_dual_half_mac (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .swap_b(swap_b), .sub_mode(sub_mode),
        .long_mode(long_mode), .acc_en(acc_en), .q_in(q_in), .q_clr(q_clr),
        .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo), .q_out(q_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // expected values from the requirement text
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] ah, input logic [31:0] al,
                         input logic sw, input logic sb, input logic lg, input logic ae,
                         output logic [31:0] rh, output logic [31:0] rl, output logic ov);
        logic [31:0] bb;
        longint p1, p2, dual, s;
        logic [63:0] sv;
        logic [31:0] d32;
        bb   = sw ? {b[15:0], b[31:16]} : b;
        p1   = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
        p2   = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        dual = sb ? p1 - p2 : p1 + p2;
        ov   = 1'b0;
        if (lg) begin
            s  = dual + (ae ? longint'({ah, al}) : 64'sd0);
            sv = s;
            rh = sv[63:32];
            rl = sv[31:0];
        end else begin
            if (!sb && (dual > 64'sd2147483647 || dual < -64'sd2147483648)) ov = 1'b1;
            sv  = dual;
            d32 = sv[31:0];
            s   = longint'($signed(d32)) + (ae ? longint'($signed(al)) : 64'sd0);
            if (ae && (s > 64'sd2147483647 || s < -64'sd2147483648)) ov = 1'b1;
            sv = s;
            rh = '0;
            rl = sv[31:0];
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; swap_b = 0; sub_mode = 0; long_mode = 0; acc_en = 0;
        q_in = 0; q_clr = 0; op_a = '0; op_b = '0; acc_hi = '0; acc_lo = '0;
    endtask

    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] ah, input logic [31:0] al,
                          input logic sw, input logic sb, input logic lg, input logic ae,
                          input logic qi, input logic qc);
        logic ov;
        @(negedge clk);
        op_a = a; op_b = b; acc_hi = ah; acc_lo = al;
        swap_b = sw; sub_mode = sb; long_mode = lg; acc_en = ae;
        q_in = qi; q_clr = qc; in_valid = 1;
        model(a, b, ah, al, sw, sb, lg, ae, exp_hi, exp_lo, ov);
        exp_q = qc ? 1'b0 : (exp_q | qi | ov);
        @(negedge clk);
        idle_inputs();
        chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " result"}, {res_hi, res_lo}, {exp_hi, exp_lo});
        chk({tag, " q"}, {63'd0, q_out}, {63'd0, exp_q});
    endtask

    task automatic clear_q();
        @(negedge clk);
        q_clr = 1;
        @(negedge clk);
        q_clr = 0;
        exp_q = 0;
        chk("R10 clear", {63'd0, q_out}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R12 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R12 reset q", {63'd0, q_out}, 64'd0);
        chk("R12 reset result", {res_hi, res_lo}, 64'd0);
    endtask

    task automatic t_basic();
        run_op("R2 R9 add", 32'h0003_0002, 32'h0005_0004, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, 0, 0, 0);
        chk("R2 value 23", {32'd0, res_lo}, 64'd23);
        run_op("R2 signed", 32'hFFFD_8000, 32'h0007_7FFF, '0, '0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_swap();
        run_op("R1 swap", 32'h0003_0002, 32'h0005_0004, '0, '0, 1, 0, 0, 0, 0, 0);
        chk("R1 value 22", {32'd0, res_lo}, 64'd22);
    endtask

    task automatic t_sub();
        run_op("R3 sub", 32'h0003_0002, 32'h0005_0004, '0, '0, 0, 1, 0, 0, 0, 0);
        chk("R3 value -7", {32'd0, res_lo}, 64'h0000_0000_FFFF_FFF9);
        run_op("R7 sub no q", 32'h8000_7FFF, 32'h7FFF_8000, '0, '0, 0, 1, 0, 0, 0, 0);
        chk("R7 sub q low", {63'd0, q_out}, 64'd0);
    endtask

    task automatic t_long();
        run_op("R4 R6 wide pos", 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 1, 0, 0, 0);
        chk("R4 boundary", {res_hi, res_lo}, 64'h0000_0000_8000_0000);
        chk("R6 no q", {63'd0, q_out}, 64'd0);
        run_op("R5 wide acc", 32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 32'hFFFF_FFF0, 0, 0, 1, 1, 0, 0);
        chk("R5 carry", {res_hi, res_lo}, 64'h0000_0001_0000_0007);
        run_op("R5 wide sub acc", 32'h7FFF_0001, 32'h7FFF_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1, 1, 0, 0);
    endtask

    task automatic t_q32();
        run_op("R7 overflow", 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 0, 0, 0, 0);
        chk("R7 q set", {63'd0, q_out}, 64'd1);
        chk("R9 hi zero", {32'd0, res_hi}, 64'd0);
        clear_q();
        run_op("R8 acc wrap", 32'h0003_0002, 32'h0005_0004, 32'hFFFF_FFFF, 32'h7FFF_FFF0, 0, 0, 0, 1, 0, 0);
        chk("R8 wrapped", {32'd0, res_lo}, 64'h0000_0000_8000_0007);
        chk("R8 q set", {63'd0, q_out}, 64'd1);
        clear_q();
    endtask

    task automatic t_sticky();
        run_op("R10 q_in", 32'h0001_0001, 32'h0001_0001, '0, '0, 0, 0, 1, 0, 1, 0);
        chk("R10 q from input", {63'd0, q_out}, 64'd1);
        run_op("R10 stays", 32'h0001_0001, 32'h0001_0001, '0, '0, 0, 1, 0, 0, 0, 0);
        chk("R10 sticky", {63'd0, q_out}, 64'd1);
        run_op("R10 clr wins", 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 0, 0, 1, 1);
        chk("R10 priority", {63'd0, q_out}, 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] prev;
        run_op("R11 load", 32'h0002_0002, 32'h0003_0003, '0, '0, 0, 0, 0, 0, 0, 0);
        prev = {res_hi, res_lo};
        @(negedge clk);
        op_a = 32'h1111_2222; op_b = 32'h3333_4444; long_mode = 1; in_valid = 0;
        @(negedge clk);
        chk("R11 valid drop", {63'd0, out_valid}, 64'd0);
        chk("R11 hold", {res_hi, res_lo}, prev);
        idle_inputs();
    endtask

    task automatic t_midreset();
        run_op("R12 pre", 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1; in_valid = 1;
        @(negedge clk);
        rst = 0; in_valid = 0;
        exp_q = 0;
        chk("R12 mid valid", {63'd0, out_valid}, 64'd0);
        chk("R12 mid q", {63'd0, q_out}, 64'd0);
        chk("R12 mid result", {res_hi, res_lo}, 64'd0);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_swap();
        t_sub();
        t_long();
        t_q32();
        t_sticky();
        t_hold();
        t_midreset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule